// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the 4-bit transmit nibbles of a media-independent interface into the serial symbol stream of a 100 Mb/s port. A one-in-five strobe tells the nibble source when the next nibble is taken. Each nibble becomes a 5-bit code group. Frame delimiters, idle and error groups are inserted around and in place of the data. The code group is then shifted out one bit per bit-clock cycle, at a line rate of 125 Mbaud.

In copper mode every serial bit is XORed with the key stream of an 11-bit self-synchronising LFSR. The result then feeds two encoders. One is an NRZI encoder. The other is a three-level MLT3 encoder whose level is given as a 2-bit signed code. In fiber mode the scrambler and the MLT3 stage are bypassed. The NRZI output then carries the unscrambled code bits and the level code rests at zero. The mode input is registered, and the port comes out of reset in copper mode.

Top module: `fetx_encoder`

## Requirements
- R1: While reset is asserted, line_nrzi is 0, mlt3_code is 2'b00 and nib_take is 0. The port leaves reset in copper mode whatever fiber_mode reads. The first nib_take pulse occurs in the cycle after the fourth rising edge following reset release.
- R2: nib_take is high for exactly one cycle in every five. tx_en, tx_er and txd are sampled at the rising edge that ends a nib_take cycle.
- R3: A data nibble maps to its code group as follows (hex nibble, group): 0 11110, 1 01001, 2 10100, 3 10101, 4 01010, 5 01011, 6 01110, 7 01111, 8 10010, 9 10011, A 10110, B 10111, C 11010, D 11011, E 11100, F 11101. Each group is sent leftmost bit first, one bit per cycle, in the five cycles after the sampling edge.
- R4: At the first sample with tx_en high after idle, the group J (11000) replaces the nibble. The next sampled nibble is replaced by K (10001), whatever tx_en and txd are.
- R5: At the first sample with tx_en low during a frame, T (01101) is sent. It is followed by R (00111) and then by idle groups (11111) until the next frame.
- R6: A data sample taken with tx_en and tx_er both high sends H (00100) instead of the nibble's group.
- R7: The scrambler has polynomial x^11 + x^9 + 1. Its state is 11'h400 after reset and it advances on every cycle. The key bit is state bit 10 XOR state bit 8, and that key is shifted in at bit 0. In copper mode the line bit is the code bit XOR key.
- R8: line_nrzi is a register that toggles at a rising edge when the line bit of the preceding cycle is 1, and holds when it is 0.
- R9: In copper mode the MLT3 level steps through 0, +1, 0, -1 (codes 2'b00, 2'b01, 2'b00, 2'b11) on each line bit of 1 and holds on 0. It starts at the first 0 of that cycle after reset. The code 2'b10 never appears.
- R10: fiber_mode is registered and acts from the cycle after the edge that captures it. In fiber mode the line bit is the unscrambled code bit, mlt3_code is 2'b00 and the MLT3 step position is frozen. The scrambler keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiber_mode | input | 1 | 1 selects fiber mode (no scrambling, no MLT3) |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | 4 | Transmit nibble |
| nib_take | output | 1 | High in the cycle whose closing edge samples the nibble |
| line_nrzi | output | 1 | Serial NRZI line bit |
| mlt3_code | output | 2 | MLT3 level: 00 zero, 01 plus, 11 minus |

## Verification
Several kinds of internal fault reach the ports within a single code group. A framer state error puts a wrong delimiter group on the line within five cycles of the faulty sample. A phase counter that slips moves nib_take and shifts every later group boundary. A scrambler state or tap fault does not change the register pattern the framer sends, but every NRZI transition that is descrambled against an independent key stream comes out wrong from the first cycle. MLT3 step errors appear as a wrong level code on the next line bit of 1. A mode register that misses reset shows up in the first cycle after release as an idle bit that was not scrambled.

// File: rtl/fetx_pkg.sv
package fetx_pkg;

  localparam int CG_W  = 5;
  localparam int SCR_W = 11;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_H    = 5'b00100;

  typedef enum logic [1:0] {FS_IDLE, FS_K, FS_DATA, FS_R} fstate_e;

  // data nibble to code group
  function automatic logic [CG_W-1:0] cg_of_nibble(input logic [3:0] n);
    logic [CG_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;  4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;  4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;  4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;  4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;  4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;  4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;  4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;  default: g = 5'b11101;
    endcase
    return g;
  endfunction

  // key bit from x^11 + x^9 + 1
  function automatic logic scr_key(input logic [SCR_W-1:0] s);
    return s[10] ^ s[8];
  endfunction

  function automatic logic [SCR_W-1:0] scr_next(input logic [SCR_W-1:0] s);
    return {s[SCR_W-2:0], scr_key(s)};
  endfunction

  // step position 0..3 to level code
  function automatic logic [1:0] mlt3_of_step(input logic [1:0] step);
    case (step)
      2'd1:    return 2'b01;
      2'd3:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fetx_framer.sv
module fetx_framer
  import fetx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic       nib_take,
  output logic       code_bit
);
  localparam int PH_W = $clog2(CG_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CG_W - 1);

  logic [PH_W-1:0] phase_q;
  fstate_e         state_q, state_n;
  logic [CG_W-1:0] shreg_q, cg_n, last_cg_q;

  assign nib_take = (phase_q == PH_LAST);
  assign code_bit = shreg_q[CG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= nib_take ? '0 : phase_q + 1'b1;
  end

  always_comb begin
    state_n = state_q;
    cg_n    = CG_IDLE;
    case (state_q)
      FS_IDLE: if (tx_en) begin cg_n = CG_J; state_n = FS_K; end
      FS_K:    begin cg_n = CG_K; state_n = FS_DATA; end
      FS_DATA: begin
        if (!tx_en)     begin cg_n = CG_T; state_n = FS_R; end
        else if (tx_er) cg_n = CG_H;
        else            cg_n = cg_of_nibble(txd);
      end
      default: begin cg_n = CG_R; state_n = FS_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FS_IDLE;
      shreg_q   <= CG_IDLE;
      last_cg_q <= CG_IDLE;
    end else if (nib_take) begin
      state_q   <= state_n;
      shreg_q   <= cg_n;
      last_cg_q <= cg_n;
    end else begin
      shreg_q   <= {shreg_q[CG_W-2:0], 1'b1};
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST);
  // R2
  take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_take |=> !nib_take);
  // R4
  k_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_take && state_q == FS_K) |-> last_cg_q == CG_J);
  // R5
  r_after_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_take && state_q == FS_R) |-> last_cg_q == CG_T);

endmodule

// File: rtl/fetx_scrambler.sv
module fetx_scrambler
  import fetx_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED = 11'h400
) (
  input  logic clk,
  input  logic rst_n,
  output logic key
);
  logic [SCR_W-1:0] lfsr_q;

  assign key = scr_key(lfsr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= scr_next(lfsr_q);
  end

  // R7
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/fetx_line.sv
module fetx_line
  import fetx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fiber_q,
  input  logic       code_bit,
  input  logic       key,
  output logic       line_nrzi,
  output logic [1:0] mlt3_code
);
  logic       line_bit;
  logic [1:0] step_q;
  logic       nrzi_q;

  assign line_bit  = fiber_q ? code_bit : (code_bit ^ key);
  assign line_nrzi = nrzi_q;
  assign mlt3_code = fiber_q ? 2'b00 : mlt3_of_step(step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q <= 1'b0;
      step_q <= 2'd0;
    end else begin
      nrzi_q <= nrzi_q ^ line_bit;
      if (!fiber_q && line_bit) step_q <= step_q + 2'd1;
    end
  end

  // R8
  nrzi_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_bit |=> line_nrzi != $past(line_nrzi));
  // R9
  mlt3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_bit |=> $stable(step_q));
  // R10
  fiber_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiber_q |=> $stable(step_q));
  // R9
  mlt3_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mlt3_code != 2'b10);

endmodule

// File: rtl/fetx_encoder.sv
module fetx_encoder
  import fetx_pkg::*;
#(
  parameter logic [SCR_W-1:0] SCR_SEED = 11'h400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fiber_mode,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic       nib_take,
  output logic       line_nrzi,
  output logic [1:0] mlt3_code
);
  logic fiber_q;
  logic code_bit;
  logic key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fiber_q <= 1'b0;
    else        fiber_q <= fiber_mode;
  end

  fetx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .nib_take(nib_take), .code_bit(code_bit)
  );

  fetx_scrambler #(.SEED(SCR_SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .key(key)
  );

  fetx_line u_line (
    .clk(clk), .rst_n(rst_n), .fiber_q(fiber_q), .code_bit(code_bit),
    .key(key), .line_nrzi(line_nrzi), .mlt3_code(mlt3_code)
  );

  // R1
  reset_copper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fiber_q);

endmodule

// File: tb/tb_fetx_encoder.sv
`timescale 1ns/1ps
module tb_fetx_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fiber_mode = 1'b1;
  logic tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic nib_take, line_nrzi;
  logic [1:0] mlt3_code;

  always #10 clk = ~clk;

  fetx_encoder dut (
    .clk(clk), .rst_n(rst_n), .fiber_mode(fiber_mode), .tx_en(tx_en),
    .tx_er(tx_er), .txd(txd), .nib_take(nib_take), .line_nrzi(line_nrzi),
    .mlt3_code(mlt3_code)
  );

  // R3 code groups indexed by nibble value
  localparam logic [4:0] CG_TAB [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  int n_tests = 0, n_fail = 0;
  logic prev_line, mode_m, last_d;
  logic [10:0] rev_lfsr;   // scrambler state held bit-reversed
  int   step_m;
  logic [4:0] hist;
  logic [4:0] pend_exp;
  string pend_tag;
  bit pend_v = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_level(input int s);
    int lvl;
    lvl = (s == 1) ? 1 : ((s == 3) ? -1 : 0);
    return 2'(lvl);
  endfunction

  // one bit time: decode the line, follow an independent scrambler and MLT3 model
  task automatic tick();
    logic d, k, used;
    @(negedge clk);
    d = line_nrzi ^ prev_line;
    prev_line = line_nrzi;
    used = mode_m;
    k = rev_lfsr[0] ^ rev_lfsr[2];
    rev_lfsr = {k, rev_lfsr[10:1]};
    if (!used && d) step_m = (step_m + 1) % 4;
    mode_m = fiber_mode;
    last_d = used ? d : (d ^ k);
    hist = {hist[3:0], last_d};
    if (mode_m) chk(mlt3_code == 2'b00, "R10", 32'(mlt3_code), 0);
    else        chk(mlt3_code == exp_level(step_m), "R9", 32'(mlt3_code), 32'(exp_level(step_m)));
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] nib,
                      input logic [4:0] exp, input string tag);
    while (!nib_take) tick();
    tx_en = en; tx_er = er; txd = nib;
    tick();
    if (pend_v) chk(hist == pend_exp, pend_tag, 32'(hist), 32'(pend_exp));
    pend_exp = exp; pend_tag = tag; pend_v = 1;
  endtask

  task automatic frame();
    step(0, 0, 4'h3, 5'b11111, "R5 idle");
    step(1, 0, 4'h5, 5'b11000, "R4 J");
    step(0, 1, 4'hD, 5'b10001, "R4 K");
    for (int i = 0; i < 16; i++) step(1, 0, 4'(i), CG_TAB[i], "R3");
    step(1, 1, 4'h0, 5'b00100, "R6 H");
    step(1, 0, 4'h9, CG_TAB[9], "R3");
    step(0, 1, 4'h7, 5'b01101, "R5 T");
    step(1, 0, 4'h7, 5'b00111, "R5 R");
    step(0, 0, 4'h0, 5'b11111, "R5 idle");
    step(0, 0, 4'h0, 5'b11111, "R5 idle");
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(line_nrzi == 1'b0, "R1 nrzi", 32'(line_nrzi), 0);
    chk(mlt3_code == 2'b00, "R1 mlt3", 32'(mlt3_code), 0);
    chk(nib_take == 1'b0, "R1 take", 32'(nib_take), 0);
    // release with fiber_mode high: first bit must still be scrambled idle
    rst_n = 1'b1;
    prev_line = line_nrzi; rev_lfsr = 11'h001; step_m = 0; mode_m = 1'b0; hist = '0;
    tick();
    chk(last_d == 1'b1 && line_nrzi == 1'b0, "R1 copper at reset", 32'(line_nrzi), 0);
    cnt = 1;
    while (!nib_take) begin tick(); cnt++; end
    chk(cnt == 4, "R1 first take", 32'(cnt), 4);
    // R2 spacing
    tick();
    cnt = 1;
    while (!nib_take) begin tick(); cnt++; end
    chk(cnt == 5, "R2 spacing", 32'(cnt), 5);
    // fiber frame (R10), then copper frame (R7 R8 R9)
    frame();
    fiber_mode = 1'b0;
    frame();
    // switch back to fiber between frames
    fiber_mode = 1'b1;
    frame();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule